// File: doc/BRIEF.md
# Asynchronous Multiplexed Memory Bus Controller

This block runs single accesses to an asynchronous external memory that shares one set of pins for address and data. A requester inside the chip offers an address, write data and a direction with a valid/ready handshake. The controller then steps the external bus through four timed phases. First comes address setup with the address-valid strobe low. Next is address hold, where the address stays on the pins with the strobe high. Then comes the data phase, where write data is driven under write enable, or the bus is released under output enable and read data is taken. Last is a turnaround phase, where every strobe is released and the pins float.

All phase lengths come from one 20-bit timing word, counted in system clock cycles. The word, the wait-enable bit and the wait-polarity bit are latched when a request is accepted. The memory may hold off an access through a wait input. That input goes through a two-flop synchronizer, and only the data phase waits on it. The finished access is reported by a one-cycle done pulse, with the captured read data held beside it.

Top module: `amux_bus_ctrl`

## Requirements
- R1: Phases run in the fixed order address setup, address hold, data, turnaround. Chip select (active low) is asserted through the first three and released in turnaround, when no strobe is active and the bus is not driven.
- R2: Timing word field positions: address setup in bits 3:0, address hold in bits 7:4, data phase in bits 15:8, turnaround in bits 19:16. Each phase lasts that many clock cycles.
- R3: An address setup or turnaround value of 0 skips that phase. An address hold or data value of 0 is illegal and is treated as 1.
- R4: In address setup the address is driven on the bus with the address-valid strobe low. In address hold the address stays driven with the strobe high.
- R5: In a write, write enable is low and the write data is driven for every data-phase cycle, and output enable stays high.
- R6: In a read, output enable is low for every data-phase cycle, the bus is not driven, and the bus value of the final data-phase cycle is returned on the read data output.
- R7: The done output pulses high for exactly one cycle, the cycle right after the last data-phase cycle, for reads and for writes.
- R8: When wait handling is disabled, the wait input has no effect on any phase length.
- R9: The polarity bit selects the active wait level: 1 means active high, 0 means active low.
- R10: When wait handling is enabled, each cycle in which the synchronized wait is active freezes the data-phase count. If wait is active before the data phase starts and is released during data cycle K, the data phase lasts K + 1 + D cycles, where D is the effective data length.
- R11: Address setup and address hold are never lengthened by wait.
- R12: Request ready is high only while the controller is idle. The timing and wait settings are latched at acceptance, so later changes do not affect the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_timing | input | 20 | Phase length word |
| cfg_wait_en | input | 1 | Enable for wait handling |
| cfg_wait_pol | input | 1 | Active level of wait (1 = high) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AD_W | Access address |
| req_wdata | input | AD_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | AD_W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_ad_o | output | AD_W | Shared bus output value |
| mem_ad_oe | output | 1 | Shared bus drive enable |
| mem_ad_i | input | AD_W | Shared bus input value |
| mem_wait | input | 1 | Wait request from the memory |

## Verification
The assertions assume that a requester keeps its request stable until it is taken, and that the wait input changes only in ways the memory would make. In particular, wait must be raised at least two clock edges before the data phase starts, so that the synchronizer has passed it on before the first data cycle. The stimulus raises wait three idle cycles before each request and drops it only at a known data-phase cycle. This keeps the expected stretch equal to the K + 1 + D rule, and the timing word is scrambled straight after acceptance to show that only the latched copy counts.

// File: rtl/amux_pkg.sv
package amux_pkg;

    localparam int CFG_W  = 20;
    localparam int AS_LSB = 0;
    localparam int AS_W   = 4;
    localparam int AH_LSB = 4;
    localparam int AH_W   = 4;
    localparam int DS_LSB = 8;
    localparam int DS_W   = 8;
    localparam int BT_LSB = 16;
    localparam int BT_W   = 4;
    localparam int CNT_W  = 8;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ASET = 3'd1,
        PH_AHLD = 3'd2,
        PH_DATA = 3'd3,
        PH_TURN = 3'd4
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] aset;
        logic [CNT_W-1:0] ahld;
        logic [CNT_W-1:0] dset;
        logic [CNT_W-1:0] turn;
    } timing_t;

    // Splits the timing word and clamps the fields that may not be zero.
    function automatic timing_t decode_timing(input logic [CFG_W-1:0] raw);
        timing_t t;
        t.aset = CNT_W'(raw[AS_LSB +: AS_W]);
        t.ahld = CNT_W'(raw[AH_LSB +: AH_W]);
        t.dset = CNT_W'(raw[DS_LSB +: DS_W]);
        t.turn = CNT_W'(raw[BT_LSB +: BT_W]);
        if (t.ahld == '0) t.ahld = CNT_W'(1);
        if (t.dset == '0) t.dset = CNT_W'(1);
        return t;
    endfunction

endpackage

// File: rtl/amux_wait_sync.sv
module amux_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_raw,
    output logic wait_sync
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = wait_raw;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], wait_raw};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign wait_sync = chain_q[STAGES-1];

endmodule

// File: rtl/amux_phase_seq.sv
module amux_phase_seq
    import amux_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_timing,
    input  logic             cfg_wait_en,
    input  logic             cfg_wait_pol,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AD_W-1:0]  req_addr,
    input  logic [AD_W-1:0]  req_wdata,
    input  logic             wait_sync,
    input  logic [AD_W-1:0]  bus_in,
    output phase_e           phase_q_o,
    output phase_e           phase_d_o,
    output logic             write_d_o,
    output logic [AD_W-1:0]  addr_d_o,
    output logic [AD_W-1:0]  wdata_d_o,
    output logic [AD_W-1:0]  rdata_o,
    output logic             done_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        timing_t          tim;
        logic             write;
        logic             wen;
        logic             pol;
        logic [AD_W-1:0]  addr;
        logic [AD_W-1:0]  wdata;
        logic [AD_W-1:0]  rdata;
        logic             done;
    } seq_t;

    seq_t    s_d;
    seq_t    s_q;
    timing_t tim_new;
    logic    hold;
    logic    last;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tim_new  = decode_timing(cfg_timing);
        hold     = s_q.wen && (wait_sync == s_q.pol);
        last     = (s_q.cnt == CNT_W'(1));
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.tim   = tim_new;
                    s_d.write = req_write;
                    s_d.wen   = cfg_wait_en;
                    s_d.pol   = cfg_wait_pol;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    if (tim_new.aset != '0) begin
                        s_d.phase = PH_ASET;
                        s_d.cnt   = tim_new.aset;
                    end else begin
                        s_d.phase = PH_AHLD;
                        s_d.cnt   = tim_new.ahld;
                    end
                end
            end
            PH_ASET: begin
                if (last) begin
                    s_d.phase = PH_AHLD;
                    s_d.cnt   = s_q.tim.ahld;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_AHLD: begin
                if (last) begin
                    s_d.phase = PH_DATA;
                    s_d.cnt   = s_q.tim.dset;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_DATA: begin
                if (!hold) begin
                    if (last) begin
                        s_d.done = 1'b1;
                        if (!s_q.write) s_d.rdata = bus_in;
                        if (s_q.tim.turn != '0) begin
                            s_d.phase = PH_TURN;
                            s_d.cnt   = s_q.tim.turn;
                        end else begin
                            s_d.phase = PH_IDLE;
                            s_d.cnt   = '0;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            PH_TURN: begin
                if (last) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
                s_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_q_o = s_q.phase;
    assign phase_d_o = s_d.phase;
    assign write_d_o = s_d.write;
    assign addr_d_o  = s_d.addr;
    assign wdata_d_o = s_d.wdata;
    assign rdata_o   = s_q.rdata;
    assign done_o    = s_q.done;

endmodule

// File: rtl/amux_pin_drv.sv
module amux_pin_drv
    import amux_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_e          phase_d,
    input  logic            write_d,
    input  logic [AD_W-1:0] addr_d,
    input  logic [AD_W-1:0] wdata_d,
    output logic            cs_n,
    output logic            oe_n,
    output logic            we_n,
    output logic            adv_n,
    output logic            ad_oe,
    output logic [AD_W-1:0] ad_o
);

    typedef struct packed {
        logic            cs_n;
        logic            oe_n;
        logic            we_n;
        logic            adv_n;
        logic            ad_oe;
        logic [AD_W-1:0] ad_o;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                    adv_n: 1'b1, ad_oe: 1'b0, ad_o: '0};

    pins_t p_d;
    pins_t p_q;

    always_comb begin
        p_d = PINS_IDLE;
        case (phase_d)
            PH_ASET: begin
                p_d.cs_n  = 1'b0;
                p_d.adv_n = 1'b0;
                p_d.ad_oe = 1'b1;
                p_d.ad_o  = addr_d;
            end
            PH_AHLD: begin
                p_d.cs_n  = 1'b0;
                p_d.ad_oe = 1'b1;
                p_d.ad_o  = addr_d;
            end
            PH_DATA: begin
                p_d.cs_n = 1'b0;
                if (write_d) begin
                    p_d.we_n  = 1'b0;
                    p_d.ad_oe = 1'b1;
                    p_d.ad_o  = wdata_d;
                end else begin
                    p_d.oe_n = 1'b0;
                end
            end
            default: p_d = PINS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= PINS_IDLE;
        else        p_q <= p_d;
    end

    assign cs_n  = p_q.cs_n;
    assign oe_n  = p_q.oe_n;
    assign we_n  = p_q.we_n;
    assign adv_n = p_q.adv_n;
    assign ad_oe = p_q.ad_oe;
    assign ad_o  = p_q.ad_o;

endmodule

// File: rtl/amux_bus_ctrl.sv
module amux_bus_ctrl
    import amux_pkg::*;
#(
    parameter int AD_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_timing,
    input  logic             cfg_wait_en,
    input  logic             cfg_wait_pol,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AD_W-1:0]  req_addr,
    input  logic [AD_W-1:0]  req_wdata,
    output logic             rsp_done,
    output logic [AD_W-1:0]  rsp_rdata,
    output logic             mem_cs_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             mem_adv_n,
    output logic [AD_W-1:0]  mem_ad_o,
    output logic             mem_ad_oe,
    input  logic [AD_W-1:0]  mem_ad_i,
    input  logic             mem_wait
);

    logic            wait_sync;
    phase_e          phase_q;
    phase_e          phase_d;
    logic            write_d;
    logic [AD_W-1:0] addr_d;
    logic [AD_W-1:0] wdata_d;

    amux_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_raw  (mem_wait),
        .wait_sync (wait_sync)
    );

    amux_phase_seq #(.AD_W(AD_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_timing   (cfg_timing),
        .cfg_wait_en  (cfg_wait_en),
        .cfg_wait_pol (cfg_wait_pol),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .wait_sync    (wait_sync),
        .bus_in       (mem_ad_i),
        .phase_q_o    (phase_q),
        .phase_d_o    (phase_d),
        .write_d_o    (write_d),
        .addr_d_o     (addr_d),
        .wdata_d_o    (wdata_d),
        .rdata_o      (rsp_rdata),
        .done_o       (rsp_done)
    );

    amux_pin_drv #(.AD_W(AD_W)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_d (phase_d),
        .write_d (write_d),
        .addr_d  (addr_d),
        .wdata_d (wdata_d),
        .cs_n    (mem_cs_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .adv_n   (mem_adv_n),
        .ad_oe   (mem_ad_oe),
        .ad_o    (mem_ad_o)
    );

    assign req_ready = (phase_q == PH_IDLE);

endmodule

// File: rtl/amux_bus_ctrl_chk.sv
module amux_bus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_done,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_adv_n,
    input logic mem_ad_oe
);

    // R1
    cs_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_adv_n || !mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    // R4
    adv_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> mem_ad_oe);

    // R5
    write_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_ad_oe && mem_oe_n));

    // R6
    read_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ad_oe && mem_we_n));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_done) |-> ($past(!mem_oe_n) || $past(!mem_we_n)));

    // R12
    ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_ad_oe));

endmodule

bind amux_bus_ctrl amux_bus_ctrl_chk chk_i (.*);

// File: tb/amux_bus_ctrl_tb_top.sv
module amux_bus_ctrl_tb_top;

    localparam int AD_W = 16;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
        logic [3:0]  as_v;
        logic [3:0]  ah_v;
        logic [7:0]  ds_v;
        logic [3:0]  bt_v;
        logic        wen;
        logic        pol;
        logic [3:0]  wk;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1234, 16'h0100, 4'd2,  4'd1,  8'd3,  4'd1,  1'b0, 1'b1, 4'd0},
        '{1'b1, 16'hA5A5, 16'h5A5A, 4'd1,  4'd1,  8'd1,  4'd1,  1'b0, 1'b1, 4'd0},
        '{1'b0, 16'h00F0, 16'h2000, 4'd0,  4'd0,  8'd0,  4'd0,  1'b0, 1'b0, 4'd0},
        '{1'b0, 16'h4321, 16'h3000, 4'd3,  4'd2,  8'd5,  4'd2,  1'b1, 1'b1, 4'd3},
        '{1'b1, 16'hBEEF, 16'hCAFE, 4'd1,  4'd3,  8'd4,  4'd1,  1'b1, 1'b0, 4'd2},
        '{1'b0, 16'h0F0F, 16'h4000, 4'd1,  4'd1,  8'd4,  4'd3,  1'b0, 1'b1, 4'd4},
        '{1'b1, 16'h7777, 16'h1357, 4'd2,  4'd2,  8'd2,  4'd0,  1'b0, 1'b0, 4'd3},
        '{1'b0, 16'hFFFE, 16'hFF00, 4'd15, 4'd15, 8'd20, 4'd15, 1'b1, 1'b1, 4'd1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [19:0]     cfg_timing = '0;
    logic            cfg_wait_en = 1'b0;
    logic            cfg_wait_pol = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [AD_W-1:0] req_addr = '0;
    logic [AD_W-1:0] req_wdata = '0;
    logic            rsp_done;
    logic [AD_W-1:0] rsp_rdata;
    logic            mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_ad_oe;
    logic [AD_W-1:0] mem_ad_o;
    logic [AD_W-1:0] mem_ad_i = '0;
    logic            wact = 1'b0;
    logic            mem_wait;

    int total = 0;
    int bad   = 0;

    assign mem_wait = cfg_wait_pol ? wact : !wact;

    always #10 clk = ~clk;

    amux_bus_ctrl #(.AD_W(AD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
        .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_adv_n(mem_adv_n), .mem_ad_o(mem_ad_o), .mem_ad_oe(mem_ad_oe),
        .mem_ad_i(mem_ad_i), .mem_wait(mem_wait)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Phase seen at the pins: 0 idle, 1 setup, 2 hold, 3 data, 4 turnaround.
    function automatic int classify();
        if (!mem_cs_n) begin
            if (!mem_adv_n) return 1;
            if (!mem_oe_n || !mem_we_n) return 3;
            return 2;
        end
        if (!req_ready) return 4;
        return 0;
    endfunction

    task automatic run_access(input vec_t v);
        int n_as = 0, n_ah = 0, n_ds = 0, n_bt = 0;
        int idx = 0, last_data = -1, done_idx = -1, done_cnt = 0;
        int order_err = 0, addr_err = 0, dir_err = 0, turn_err = 0;
        int last_ph = 0, guard = 0;
        int e_ah, e_ds_eff, e_ds;
        logic [15:0] got_rdata = '0;
        logic started = 1'b0;
        logic running = 1'b1;
        string dtag;

        @(negedge clk);
        cfg_timing   = {v.bt_v, v.ds_v, v.ah_v, v.as_v};
        cfg_wait_en  = v.wen;
        cfg_wait_pol = v.pol;
        wact         = (v.wk != 0);
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        req_write = v.wr;
        req_addr  = v.addr;
        req_wdata = v.data;
        while (running && guard < 4000) begin
            int ph;
            @(negedge clk);
            guard++;
            if (idx == 0) begin
                req_valid  = 1'b0;
                cfg_timing = ~cfg_timing;
            end
            idx++;
            ph = classify();
            if (ph != 0 && ph < last_ph) order_err++;
            if (ph != 0) last_ph = ph;
            if (rsp_done) begin
                done_cnt++;
                done_idx  = idx;
                got_rdata = rsp_rdata;
            end
            case (ph)
                1: begin n_as++; if (!mem_ad_oe || mem_ad_o != v.addr) addr_err++; end
                2: begin n_ah++; if (!mem_ad_oe || mem_ad_o != v.addr) addr_err++; end
                3: begin
                    n_ds++;
                    last_data = idx;
                    if (v.wr) begin
                        if (!mem_ad_oe || mem_ad_o != v.data || !mem_oe_n || mem_we_n) dir_err++;
                    end else begin
                        if (mem_ad_oe || mem_oe_n || !mem_we_n) dir_err++;
                        mem_ad_i = v.data + 16'(n_ds);
                    end
                    if (wact && n_ds == int'(v.wk)) wact = 1'b0;
                end
                4: begin n_bt++; if (mem_ad_oe || !mem_oe_n || !mem_we_n || !mem_adv_n) turn_err++; end
                default: ;
            endcase
            if (req_ready && started) running = 1'b0;
            if (!req_ready) started = 1'b1;
        end
        wact = 1'b0;
        cfg_timing = ~cfg_timing;

        e_ah     = (v.ah_v == 0) ? 1 : int'(v.ah_v);
        e_ds_eff = (v.ds_v == 0) ? 1 : int'(v.ds_v);
        e_ds     = (v.wen && v.wk != 0) ? int'(v.wk) + 1 + e_ds_eff : e_ds_eff;
        dtag     = !v.wen ? "R8 data length, wait ignored" :
                   (v.pol ? "R10 data length, wait stretch" : "R9 data length, low-active wait");

        chk(guard < 4000, "access finished R12", guard, 0);
        chk(order_err == 0, "R1 phase order", order_err, 0);
        chk(turn_err == 0, "R1 turnaround released", turn_err, 0);
        chk(n_as == int'(v.as_v), "R2 R3 R11 setup length", n_as, int'(v.as_v));
        chk(n_ah == e_ah, "R2 R3 R11 hold length", n_ah, e_ah);
        chk(n_ds == e_ds, dtag, n_ds, e_ds);
        chk(n_bt == int'(v.bt_v), "R2 R3 R12 turnaround length", n_bt, int'(v.bt_v));
        chk(addr_err == 0, "R4 address on bus", addr_err, 0);
        if (v.wr) chk(dir_err == 0, "R5 write data phase", dir_err, 0);
        else      chk(dir_err == 0, "R6 read data phase", dir_err, 0);
        chk(done_cnt == 1, "R7 done count", done_cnt, 1);
        chk(done_idx == last_data + 1, "R7 done timing", done_idx, last_data + 1);
        if (!v.wr)
            chk(got_rdata == v.data + 16'(e_ds), "R6 read data capture",
                int'(got_rdata), int'(v.data + 16'(e_ds)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state.
        chk(mem_cs_n && mem_oe_n && mem_we_n && mem_adv_n, "R1 strobes idle in reset",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n}, 15);
        chk(!mem_ad_oe, "R1 bus released in reset", mem_ad_oe, 0);
        chk(!rsp_done, "R7 no done in reset", rsp_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R12 ready after reset", req_ready, 1);

        for (int i = 0; i < NV; i++) run_access(VECS[i]);

        // No request: controller stays idle.
        begin
            int busy = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (!req_ready || !mem_cs_n || rsp_done) busy++;
            end
            chk(busy == 0, "R12 idle without request", busy, 0);
        end

        // Back-to-back access after idle with minimal timing.
        run_access('{1'b1, 16'h0001, 16'h8001, 4'd0, 4'd1, 8'd1, 4'd0, 1'b1, 1'b0, 4'd0});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule